// File: doc/BRIEF.md
# Write-Across Cluster Register File

This block is the register file of a single cluster in a one-way ring of processing clusters. It holds sixteen 32-bit registers shared by two ALUs and one load/store unit. Each of the three units has a pair of read ports, which gives six read ports in total. Each unit also has one write port.

The result from ALU0 carries a five-bit destination tag. The top bit of that tag steers the write:

- When the top bit is clear, the result goes into this cluster's file.
- When the top bit is set, the result leaves on the outbound ring link. It travels there as a valid bit, a register index and a data word, and the next cluster stores it.

ALU1 and load/store results always stay local. A fourth write port takes the inbound ring write from the previous cluster.

Every write made in a cycle is visible on the read ports in that same cycle. When several writers hit one register, a fixed priority decides which value wins, and a collision output reports the conflict.

The ring links follow a stream view of data movement, but they carry no ready signal. A register file accepts a write in every cycle, so there is never any back-pressure. A transfer happens in each cycle in which the valid bit is high. The sender must not hold valid high expecting a retry, because none is needed.

Top module: `crf_top`

## Requirements
- R1: After reset, every register reads as zero, and the outbound valid and collision outputs are low.
- R2: An ALU0 write whose destination tag has bit 4 at 0 stores the result into local register tag[3:0]. The value is readable from the next cycle on.
- R3: An ALU0 write whose destination tag has bit 4 at 1 drives ring_out_vld high in the same cycle, with ring_out_dst set to tag[3:0] and ring_out_data set to the result. The local file is left unchanged.
- R4: ALU1 and load/store writes go to the local file only, and never raise ring_out_vld.
- R5: An inbound ring write (ring_in_vld high) stores ring_in_data into local register ring_in_dst.
- R6: A read port addressing a register that is being written in the current cycle returns the new value in that same cycle.
- R7: When several writers target one register in a cycle, the priority is: inbound ring first, then ALU0, then ALU1, then load/store. Both the stored value and the bypassed value follow this order.
- R8: wr_collide is high in the cycle in which two or more local-file writes target the same register. An ALU0 write sent across the ring does not count toward a collision.
- R9: A register that no port writes keeps its value.
- R10: The six read ports are independent of each other, and register 0 stores and returns data like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu0_we | input | 1 | ALU0 result valid |
| alu0_dst | input | 5 | ALU0 destination tag; bit 4 selects the next cluster |
| alu0_res | input | 32 | ALU0 result |
| alu1_we | input | 1 | ALU1 result valid |
| alu1_dst | input | 4 | ALU1 destination register |
| alu1_res | input | 32 | ALU1 result |
| ls_we | input | 1 | Load/store result valid |
| ls_dst | input | 4 | Load/store destination register |
| ls_res | input | 32 | Load/store result |
| ring_in_vld | input | 1 | Write arriving from the previous cluster |
| ring_in_dst | input | 4 | Register index of the inbound write |
| ring_in_data | input | 32 | Data of the inbound write |
| ring_out_vld | output | 1 | Write leaving for the next cluster |
| ring_out_dst | output | 4 | Register index of the outbound write |
| ring_out_data | output | 32 | Data of the outbound write |
| rd_addr | input | 24 | Six 4-bit read addresses; port p uses bits [4p+3:4p] |
| rd_data | output | 192 | Six 32-bit read results; port p uses bits [32p+31:32p] |
| wr_collide | output | 1 | Two or more local writes hit one register this cycle |

## Verification
The bench drives all four writers at one register in the same cycle. It then repeats this with smaller subsets of writers. A wrong priority order would store, or bypass, a value from a lower-ranked unit.

It sends an ALU0 result across the ring while load/store writes the same local index. A design that decoded the tag badly would either corrupt the local register or raise a false collision.

It reads registers in the very cycle they are written, from several ports at once. A missing or mis-prioritised bypass shows up as a stale value.

After cross-cluster writes, it checks that registers which were never written still hold their values.

// File: rtl/crf_pkg.sv
package crf_pkg;
  // Write source order doubles as priority: lower index wins.
  typedef enum logic [1:0] {
    SRC_RING = 2'd0,
    SRC_ALU0 = 2'd1,
    SRC_ALU1 = 2'd2,
    SRC_LS   = 2'd3
  } wr_src_e;
  localparam int unsigned NUM_WR = 4;
endpackage

// File: rtl/crf_wr_merge.sv
module crf_wr_merge #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 32,
  parameter int unsigned NWR  = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [NWR-1:0]             we,
  input  logic [NWR-1:0][AW-1:0]     addr,
  input  logic [NWR-1:0][W-1:0]      data,
  output logic [NREG-1:0]            reg_wen,
  output logic [NREG-1:0][W-1:0]     reg_wdata,
  output logic                       collide
);
  logic [NREG-1:0] reg_clash;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [NWR-1:0] hit;
    always_comb begin
      int unsigned cnt;
      cnt = 0;
      reg_wdata[r] = '0;
      for (int p = NWR - 1; p >= 0; p--) begin
        hit[p] = we[p] && (addr[p] == AW'(r));
        if (hit[p]) begin
          reg_wdata[r] = data[p];
          cnt = cnt + 1;
        end
      end
      reg_wen[r]   = |hit;
      reg_clash[r] = (cnt > 1);
    end
  end

  assign collide = |reg_clash;
endmodule

// File: rtl/crf_store.sv
module crf_store #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        wen,
  input  logic [NREG-1:0][W-1:0] wdata,
  output logic [NREG-1:0][W-1:0] q
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[r] <= '0;
      else if (wen[r]) q[r] <= wdata[r];
    end

    // R2 / R5: a selected write lands in the flop at the next edge
    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wen[r] |=> q[r] == $past(wdata[r]));
    // R9: no write selected means the register holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wen[r] |=> $stable(q[r]));
  end
endmodule

// File: rtl/crf_read_port.sv
module crf_read_port #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic [NREG-1:0][W-1:0] q,
  input  logic [NREG-1:0]        wen,
  input  logic [NREG-1:0][W-1:0] wdata,
  output logic [W-1:0]           rdata
);
  always_comb begin
    if (wen[addr]) rdata = wdata[addr];
    else           rdata = q[addr];
  end

  // R6: same-cycle write is forwarded
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wen[addr] |-> rdata == wdata[addr]);
  // R10: otherwise the stored content is returned
  p_stored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wen[addr] |-> rdata == q[addr]);
endmodule

// File: rtl/crf_top.sv
module crf_top #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 32,
  parameter int unsigned NRD  = 6,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu0_we,
  input  logic [AW:0]       alu0_dst,
  input  logic [W-1:0]      alu0_res,
  input  logic              alu1_we,
  input  logic [AW-1:0]     alu1_dst,
  input  logic [W-1:0]      alu1_res,
  input  logic              ls_we,
  input  logic [AW-1:0]     ls_dst,
  input  logic [W-1:0]      ls_res,
  input  logic              ring_in_vld,
  input  logic [AW-1:0]     ring_in_dst,
  input  logic [W-1:0]      ring_in_data,
  output logic              ring_out_vld,
  output logic [AW-1:0]     ring_out_dst,
  output logic [W-1:0]      ring_out_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*W-1:0]  rd_data,
  output logic              wr_collide
);
  import crf_pkg::*;

  logic                       alu0_cross;
  logic [NUM_WR-1:0]          wp_we;
  logic [NUM_WR-1:0][AW-1:0]  wp_addr;
  logic [NUM_WR-1:0][W-1:0]   wp_data;
  logic [NREG-1:0]            reg_wen;
  logic [NREG-1:0][W-1:0]     reg_wdata;
  logic [NREG-1:0][W-1:0]     q;

  // Top tag bit steers ALU0 onto the ring instead of the local file
  assign alu0_cross = alu0_dst[AW];

  always_comb begin
    wp_we[SRC_RING]   = ring_in_vld;
    wp_addr[SRC_RING] = ring_in_dst;
    wp_data[SRC_RING] = ring_in_data;
    wp_we[SRC_ALU0]   = alu0_we && !alu0_cross;
    wp_addr[SRC_ALU0] = alu0_dst[AW-1:0];
    wp_data[SRC_ALU0] = alu0_res;
    wp_we[SRC_ALU1]   = alu1_we;
    wp_addr[SRC_ALU1] = alu1_dst;
    wp_data[SRC_ALU1] = alu1_res;
    wp_we[SRC_LS]     = ls_we;
    wp_addr[SRC_LS]   = ls_dst;
    wp_data[SRC_LS]   = ls_res;
  end

  assign ring_out_vld  = alu0_we && alu0_cross;
  assign ring_out_dst  = alu0_dst[AW-1:0];
  assign ring_out_data = alu0_res;

  crf_wr_merge #(.NREG(NREG), .W(W), .NWR(NUM_WR)) u_merge (
    .we(wp_we), .addr(wp_addr), .data(wp_data),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .collide(wr_collide)
  );

  crf_store #(.NREG(NREG), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .wdata(reg_wdata), .q(q)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    crf_read_port #(.NREG(NREG), .W(W)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .addr(rd_addr[p*AW +: AW]),
      .q(q), .wen(reg_wen), .wdata(reg_wdata),
      .rdata(rd_data[p*W +: W])
    );
  end
endmodule

// File: tb/tb_crf_top.sv
module tb_crf_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRD = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        alu0_we = 0;  logic [4:0] alu0_dst = '0; logic [31:0] alu0_res = '0;
  logic        alu1_we = 0;  logic [3:0] alu1_dst = '0; logic [31:0] alu1_res = '0;
  logic        ls_we = 0;    logic [3:0] ls_dst = '0;   logic [31:0] ls_res = '0;
  logic        ring_in_vld = 0; logic [3:0] ring_in_dst = '0; logic [31:0] ring_in_data = '0;
  logic        ring_out_vld; logic [3:0] ring_out_dst; logic [31:0] ring_out_data;
  logic [23:0] rd_addr = '0;
  logic [191:0] rd_data;
  logic        wr_collide;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crf_top dut (
    .clk(clk), .rst_n(rst_n),
    .alu0_we(alu0_we), .alu0_dst(alu0_dst), .alu0_res(alu0_res),
    .alu1_we(alu1_we), .alu1_dst(alu1_dst), .alu1_res(alu1_res),
    .ls_we(ls_we), .ls_dst(ls_dst), .ls_res(ls_res),
    .ring_in_vld(ring_in_vld), .ring_in_dst(ring_in_dst), .ring_in_data(ring_in_data),
    .ring_out_vld(ring_out_vld), .ring_out_dst(ring_out_dst), .ring_out_data(ring_out_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_collide(wr_collide)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu0_we = 0; alu1_we = 0; ls_we = 0; ring_in_vld = 0;
  endtask

  // Drive at negedge, let combinational outputs settle.
  task automatic settle();
    #1;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle(); settle();
  endtask

  // All six ports read one register and are compared.
  task automatic read_all(input string req, input logic [3:0] a, input logic [31:0] exp);
    for (int p = 0; p < NRD; p++) rd_addr[p*4 +: 4] = a;
    settle();
    for (int p = 0; p < NRD; p++) chk(req, rd_data[p*32 +: 32], exp);
  endtask

  task automatic t_reset();
    for (int r = 0; r < 16; r++) read_all("R1 reg zero", 4'(r), 32'h0);
    chk("R1 ring_out_vld", {31'b0, ring_out_vld}, 32'h0);
    chk("R1 wr_collide", {31'b0, wr_collide}, 32'h0);
  endtask

  task automatic t_alu0_local();
    @(negedge clk);
    alu0_we = 1; alu0_dst = 5'h05; alu0_res = 32'hA5A5_0005;
    settle();
    chk("R2 no ring out", {31'b0, ring_out_vld}, 32'h0);
    step();
    read_all("R2 alu0 local", 4'h5, 32'hA5A5_0005);
  endtask

  task automatic t_alu0_cross();
    @(negedge clk);
    alu0_we = 1; alu0_dst = 5'h17; alu0_res = 32'hBEEF_0007;
    settle();
    chk("R3 ring_out_vld", {31'b0, ring_out_vld}, 32'h1);
    chk("R3 ring_out_dst", {28'b0, ring_out_dst}, 32'h7);
    chk("R3 ring_out_data", ring_out_data, 32'hBEEF_0007);
    step();
    chk("R3 ring_out drops", {31'b0, ring_out_vld}, 32'h0);
    read_all("R3 local untouched", 4'h7, 32'h0);
  endtask

  task automatic t_local_units();
    @(negedge clk);
    alu1_we = 1; alu1_dst = 4'h9; alu1_res = 32'h1111_0009;
    ls_we = 1;   ls_dst = 4'hA;   ls_res = 32'h2222_000A;
    settle();
    chk("R4 no ring out", {31'b0, ring_out_vld}, 32'h0);
    chk("R4 no collide", {31'b0, wr_collide}, 32'h0);
    step();
    read_all("R4 alu1 local", 4'h9, 32'h1111_0009);
    read_all("R4 ls local", 4'hA, 32'h2222_000A);
  endtask

  task automatic t_ring_in();
    @(negedge clk);
    ring_in_vld = 1; ring_in_dst = 4'hC; ring_in_data = 32'hC0FF_EE0C;
    settle();
    step();
    read_all("R5 ring in stored", 4'hC, 32'hC0FF_EE0C);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    ring_in_vld = 1; ring_in_dst = 4'h3; ring_in_data = 32'h3333_0003;
    alu1_we = 1;     alu1_dst = 4'hB;    alu1_res = 32'hBBBB_000B;
    rd_addr = '0;
    rd_addr[0 +: 4] = 4'h3; rd_addr[20 +: 4] = 4'hB; rd_addr[8 +: 4] = 4'h5;
    settle();
    chk("R6 bypass ring", rd_data[0 +: 32], 32'h3333_0003);
    chk("R6 bypass alu1", rd_data[160 +: 32], 32'hBBBB_000B);
    chk("R6 unrelated port", rd_data[64 +: 32], 32'hA5A5_0005);
    step();
  endtask

  task automatic t_priority();
    @(negedge clk);
    ring_in_vld = 1; ring_in_dst = 4'h4; ring_in_data = 32'h1111_1111;
    alu0_we = 1; alu0_dst = 5'h04; alu0_res = 32'h2222_2222;
    alu1_we = 1; alu1_dst = 4'h4;  alu1_res = 32'h3333_3333;
    ls_we = 1;   ls_dst = 4'h4;    ls_res = 32'h4444_4444;
    read_all("R7 bypass ring wins", 4'h4, 32'h1111_1111);
    chk("R8 collide four", {31'b0, wr_collide}, 32'h1);
    step();
    read_all("R7 stored ring wins", 4'h4, 32'h1111_1111);
    @(negedge clk);
    alu0_we = 1; alu0_dst = 5'h06; alu0_res = 32'h2222_2222;
    alu1_we = 1; alu1_dst = 4'h6;  alu1_res = 32'h3333_3333;
    ls_we = 1;   ls_dst = 4'h6;    ls_res = 32'h4444_4444;
    read_all("R7 bypass alu0 wins", 4'h6, 32'h2222_2222);
    step();
    read_all("R7 stored alu0 wins", 4'h6, 32'h2222_2222);
    @(negedge clk);
    alu1_we = 1; alu1_dst = 4'h8;  alu1_res = 32'h3333_3333;
    ls_we = 1;   ls_dst = 4'h8;    ls_res = 32'h4444_4444;
    settle();
    chk("R8 collide two", {31'b0, wr_collide}, 32'h1);
    step();
    read_all("R7 stored alu1 wins", 4'h8, 32'h3333_3333);
  endtask

  task automatic t_cross_no_collide();
    @(negedge clk);
    alu0_we = 1; alu0_dst = 5'h12; alu0_res = 32'h9999_9999;
    ls_we = 1;   ls_dst = 4'h2;    ls_res = 32'h5555_0002;
    settle();
    chk("R8 cross not counted", {31'b0, wr_collide}, 32'h0);
    chk("R3 ring out with ls", {31'b0, ring_out_vld}, 32'h1);
    step();
    chk("R8 collide clears", {31'b0, wr_collide}, 32'h0);
    read_all("R8 ls value kept", 4'h2, 32'h5555_0002);
  endtask

  task automatic t_reg0_ports();
    @(negedge clk);
    ls_we = 1; ls_dst = 4'h0; ls_res = 32'h0000_D00D;
    settle();
    step();
    rd_addr = {4'h0, 4'hC, 4'h9, 4'h5, 4'hA, 4'h0};
    settle();
    chk("R10 port0 reg0", rd_data[0 +: 32],   32'h0000_D00D);
    chk("R10 port1 regA", rd_data[32 +: 32],  32'h2222_000A);
    chk("R10 port2 reg5", rd_data[64 +: 32],  32'hA5A5_0005);
    chk("R10 port3 reg9", rd_data[96 +: 32],  32'h1111_0009);
    chk("R10 port4 regC", rd_data[128 +: 32], 32'hC0FF_EE0C);
    chk("R10 port5 reg0", rd_data[160 +: 32], 32'h0000_D00D);
  endtask

  task automatic t_hold();
    read_all("R9 reg5 held", 4'h5, 32'hA5A5_0005);
    read_all("R9 reg7 held", 4'h7, 32'h0);
    read_all("R9 regF held", 4'hF, 32'h0);
    read_all("R9 reg3 held", 4'h3, 32'h3333_0003);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    settle();
    t_reset();
    rst_n = 1;
    @(negedge clk); settle();
    t_reset();
    t_alu0_local();
    t_alu0_cross();
    t_local_units();
    t_ring_in();
    t_bypass();
    t_priority();
    t_cross_no_collide();
    t_reg0_ports();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule